// File: doc/BRIEF.md
# Cascadable Nibble Add/Subtract Chain

This block adds or subtracts two operands using 4-bit arithmetic slices. Inside each slice, four bit cells pass a carry from one to the next. Each cell forms a generate term and a propagate term from its two operand bits. The propagate term decides whether the incoming ripple bit passes through to the cell's carry-out. The generate term decides whether the cell makes a carry of its own. One operation-select input controls every cell. When it is set, each B bit is inverted before it enters its cell. With a carry-in of 1 at the least significant slice, this gives the two's-complement difference A − B.

The first slice takes its carry-in from one of four sources, chosen by a static 2-bit code:
- the cascade input from a neighbouring chain,
- a general data input,
- constant one,
- constant zero.

Inside the wrapper, every later slice takes the carry-out of the slice below it. The wrapper stacks `NUM_SLICES` slices and reports the following:
- the full-width result,
- the final carry on two separately enabled outputs (a cascade port and a general port),
- a signed-overflow flag.

The block is purely combinational. It has no valid/ready handshake and no back-pressure: every output follows its inputs in the same cycle, and the configuration pins are expected to stay static.

Top module: `nib_ripple_chain`

## Requirements
- R1: With `op_sub`=0, `result` equals (`opnd_a` + `opnd_b` + carry-in) modulo 2^(4·NUM_SLICES).
- R2: With `op_sub`=1, every B bit is inverted before addition, so `result` = `opnd_a` + ~`opnd_b` + carry-in. When the carry-in is 1, this is `opnd_a` − `opnd_b`.
- R3: `cin_src` selects the carry-in of the lowest slice. Code 0 selects `chain_in`, code 1 selects `cin_data`, code 2 selects constant 1, and code 3 selects constant 0. Sources that are not selected have no effect on any output.
- R4: The final carry is bit 4·NUM_SLICES of the sum `opnd_a` + B' + carry-in, where B' is B after the optional inversion.
- R5: `cout_en` bit 0 enables `cout_chain` and bit 1 enables `cout_flag`. An enabled output shows the final carry, and a disabled output is 0.
- R6: `ovf` equals the carry into the top bit XOR the carry out of the top bit. This is 1 exactly when `opnd_a` and B' have the same sign and `result` has the opposite sign.
- R7: Slices chain carry-out to carry-in, so R1–R6 hold for NUM_SLICES of 1, 2 and 4.
- R8: The outputs are combinational: they reflect the current inputs without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 4·NUM_SLICES | First operand |
| opnd_b | input | 4·NUM_SLICES | Second operand, inverted per bit when subtracting |
| op_sub | input | 1 | 1 = subtract (invert B), 0 = add |
| cin_src | input | 2 | Carry-in source code for the lowest slice |
| chain_in | input | 1 | Cascade carry from a neighbouring chain |
| cin_data | input | 1 | General data input usable as carry-in |
| cout_en | input | 2 | Bit 0 enables cout_chain, bit 1 enables cout_flag |
| result | output | 4·NUM_SLICES | Sum or difference |
| cout_chain | output | 1 | Final carry on the cascade port, 0 if disabled |
| cout_flag | output | 1 | Final carry on the general port, 0 if disabled |
| ovf | output | 1 | Signed overflow |

## Verification
The operands are swept over fixed corner patterns for both operations, every carry-in code, every output-enable code and both levels of the two alternate carry sources:
- All zeros and all ones separate a carry rippling through every cell from one that stops early.
- The values just below and at the sign boundary separate a correct overflow from a plain carry-out.
- Holding the unselected carry sources at both levels shows whether the source select leaks.

Random operands then run on chains of one, two and four slices against a behavioural add/subtract model. This shows whether carries cross slice boundaries correctly.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB = 4;

  typedef enum logic [1:0] {
    CIN_CHAIN = 2'd0,
    CIN_DATA  = 2'd1,
    CIN_ONE   = 2'd2,
    CIN_ZERO  = 2'd3
  } cin_src_e;
endpackage

// File: rtl/nib_cin_mux.sv
module nib_cin_mux
  import nib_pkg::*;
(
  input  cin_src_e sel,
  input  logic     chain_in,
  input  logic     data_in,
  output logic     cin
);
  always_comb begin
    unique case (sel)
      CIN_CHAIN: cin = chain_in;
      CIN_DATA:  cin = data_in;
      CIN_ONE:   cin = 1'b1;
      default:   cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_bit_cell.sv
module nib_bit_cell (
  input  logic a,
  input  logic b,
  input  logic inv_b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic b_eff, gen, prop;

  always_comb begin
    b_eff = b ^ inv_b;
    gen   = a & b_eff;
    prop  = a ^ b_eff;
    sum   = prop ^ cin;
    cout  = gen | (prop & cin);
  end

  // R1/R2: the gate-level cell agrees with a two-bit arithmetic sum
  always_comb begin
    assert_cell_sum_R1: assert ({cout, sum} == (2'(a) + 2'(b ^ inv_b) + 2'(cin)))
      else $error("cell sum mismatch");
  end
endmodule

// File: rtl/nib_slice.sv
module nib_slice
  import nib_pkg::*;
(
  input  logic [NIB-1:0] a,
  input  logic [NIB-1:0] b,
  input  logic           inv_b,
  input  cin_src_e       cin_sel,
  input  logic           chain_in,
  input  logic           data_in,
  output logic [NIB-1:0] res,
  output logic           cout,
  output logic           ovf
);
  logic [NIB:0] rip;

  nib_cin_mux u_cin (
    .sel      (cin_sel),
    .chain_in (chain_in),
    .data_in  (data_in),
    .cin      (rip[0])
  );

  for (genvar i = 0; i < NIB; i++) begin : g_cell
    nib_bit_cell u_cell (
      .a     (a[i]),
      .b     (b[i]),
      .inv_b (inv_b),
      .cin   (rip[i]),
      .sum   (res[i]),
      .cout  (rip[i+1])
    );
  end

  assign cout = rip[NIB];
  assign ovf  = rip[NIB-1] ^ rip[NIB];

  // R4: slice carry-out is the top bit of the 5-bit sum
  always_comb begin
    assert_slice_carry_R4: assert ({cout, res} ==
        ((NIB+1)'(a) + (NIB+1)'(b ^ {NIB{inv_b}}) + (NIB+1)'(rip[0])))
      else $error("slice carry mismatch");
  end
endmodule

// File: rtl/nib_cout_gate.sv
module nib_cout_gate (
  input  logic       carry,
  input  logic [1:0] en,
  output logic       to_chain,
  output logic       to_flag
);
  assign to_chain = carry & en[0];
  assign to_flag  = carry & en[1];
endmodule

// File: rtl/nib_ripple_chain.sv
module nib_ripple_chain
  import nib_pkg::*;
#(
  parameter int NUM_SLICES = 2
) (
  input  logic [NUM_SLICES*4-1:0] opnd_a,
  input  logic [NUM_SLICES*4-1:0] opnd_b,
  input  logic                    op_sub,
  input  logic [1:0]              cin_src,
  input  logic                    chain_in,
  input  logic                    cin_data,
  input  logic [1:0]              cout_en,
  output logic [NUM_SLICES*4-1:0] result,
  output logic                    cout_chain,
  output logic                    cout_flag,
  output logic                    ovf
);
  localparam int W = NUM_SLICES * NIB;

  logic [NUM_SLICES:0]   carry;
  logic [NUM_SLICES-1:0] slice_ovf;

  assign carry[0] = chain_in;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam cin_src_e SEL_FIXED = CIN_CHAIN;
    cin_src_e sel_k;
    logic     data_k;
    if (k == 0) begin : g_low
      assign sel_k  = cin_src_e'(cin_src);
      assign data_k = cin_data;
    end else begin : g_upper
      assign sel_k  = SEL_FIXED;
      assign data_k = 1'b0;
    end

    nib_slice u_slice (
      .a        (opnd_a[k*NIB +: NIB]),
      .b        (opnd_b[k*NIB +: NIB]),
      .inv_b    (op_sub),
      .cin_sel  (sel_k),
      .chain_in (carry[k]),
      .data_in  (data_k),
      .res      (result[k*NIB +: NIB]),
      .cout     (carry[k+1]),
      .ovf      (slice_ovf[k])
    );

    // R6: the per-slice overflow matches the sign rule on that slice's top bit
    always_comb begin
      assert_slice_ovf_R6: assert (slice_ovf[k] ==
          ((opnd_a[k*NIB+NIB-1] == (opnd_b[k*NIB+NIB-1] ^ op_sub)) &&
           (result[k*NIB+NIB-1] != opnd_a[k*NIB+NIB-1])))
        else $error("overflow sign rule mismatch");
    end
  end

  assign ovf = slice_ovf[NUM_SLICES-1];

  nib_cout_gate u_gate (
    .carry    (carry[NUM_SLICES]),
    .en       (cout_en),
    .to_chain (cout_chain),
    .to_flag  (cout_flag)
  );

  // R5: outputs are 0 when disabled and agree when both are enabled
  always_comb begin
    assert_cout_disabled_R5: assert (!(cout_chain && !cout_en[0]) && !(cout_flag && !cout_en[1]))
      else $error("disabled carry output active");
    assert_cout_both_R5: assert (cout_en != 2'b11 || cout_chain == cout_flag)
      else $error("carry outputs disagree");
  end

  // R2: subtract with a forced carry-in of one yields a - b
  always_comb begin
    assert_sub_diff_R2: assert (!(op_sub && cin_src == 2'd2) ||
                                result == W'(opnd_a - opnd_b))
      else $error("difference mismatch");
  end
endmodule

// File: tb/nib_ripple_chain_tb_top.sv
module nib_ripple_chain_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, b;
  logic        sub, chain, data;
  logic [1:0]  sel, en;

  logic [15:0] r4; logic cc4, cf4, v4;
  logic [7:0]  r2; logic cc2, cf2, v2;
  logic [3:0]  r1; logic cc1, cf1, v1;

  nib_ripple_chain #(.NUM_SLICES(4)) dut_i (
    .opnd_a(a), .opnd_b(b), .op_sub(sub), .cin_src(sel), .chain_in(chain),
    .cin_data(data), .cout_en(en), .result(r4), .cout_chain(cc4),
    .cout_flag(cf4), .ovf(v4));
  nib_ripple_chain #(.NUM_SLICES(2)) dut_n2 (
    .opnd_a(a[7:0]), .opnd_b(b[7:0]), .op_sub(sub), .cin_src(sel), .chain_in(chain),
    .cin_data(data), .cout_en(en), .result(r2), .cout_chain(cc2),
    .cout_flag(cf2), .ovf(v2));
  nib_ripple_chain #(.NUM_SLICES(1)) dut_n1 (
    .opnd_a(a[3:0]), .opnd_b(b[3:0]), .op_sub(sub), .cin_src(sel), .chain_in(chain),
    .cin_data(data), .cout_en(en), .result(r1), .cout_chain(cc1),
    .cout_flag(cf1), .ovf(v1));

  typedef struct {
    logic [15:0] res [3];
    logic        cc  [3];
    logic        cf  [3];
    logic        ov  [3];
    bit          sub;
    logic [1:0]  sel;
  } exp_t;

  exp_t scb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // R3: code 0 chain, 1 data, 2 one, 3 zero
  function automatic logic pick_cin(logic [1:0] s, logic ch, logic dt);
    case (s)
      2'd0: return ch;
      2'd1: return dt;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(int w, logic [15:0] ia, logic [15:0] ib, bit isub, logic ci,
                       logic [1:0] ien, output logic [15:0] res, output logic cc,
                       output logic cf, output logic ov);
    longint m, aa, bx, full;
    logic c;
    m    = (longint'(1) << w) - 1;
    aa   = longint'(ia) & m;
    bx   = (isub ? ~longint'(ib) : longint'(ib)) & m;
    full = aa + bx + longint'(ci);
    res  = 16'(full & m);
    c    = full[w];
    cc   = c & ien[0];
    cf   = c & ien[1];
    ov   = (aa[w-1] == bx[w-1]) && (full[w-1] != aa[w-1]);
  endtask

  task automatic drive(logic [15:0] ia, logic [15:0] ib, bit isub, logic [1:0] isel,
                       logic ich, logic idt, logic [1:0] ien);
    exp_t e;
    logic ci;
    @(negedge clk);
    a = ia; b = ib; sub = isub; sel = isel; chain = ich; data = idt; en = ien;
    ci = pick_cin(isel, ich, idt);
    model(16, ia, ib, isub, ci, ien, e.res[0], e.cc[0], e.cf[0], e.ov[0]);
    model(8,  ia, ib, isub, ci, ien, e.res[1], e.cc[1], e.cf[1], e.ov[1]);
    model(4,  ia, ib, isub, ci, ien, e.res[2], e.cc[2], e.cf[2], e.ov[2]);
    e.sub = isub; e.sel = isel;
    scb_q.push_back(e);
  endtask

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scb_q.size() > 0) begin
        exp_t e;
        logic [15:0] ar [3];
        logic ac [3], af [3], av [3];
        string rt;
        e = scb_q.pop_front();
        ar[0] = r4; ar[1] = {8'h0, r2}; ar[2] = {12'h0, r1};
        ac[0] = cc4; ac[1] = cc2; ac[2] = cc1;
        af[0] = cf4; af[1] = cf2; af[2] = cf1;
        av[0] = v4;  av[1] = v2;  av[2] = v1;
        rt = e.sub ? "R2" : "R1";
        for (int k = 0; k < 3; k++) begin
          string sz;
          sz = $sformatf(" R7 slices=%0d R3 sel=%0d", 4 >> k, e.sel);
          cmp({rt, " result", sz}, ar[k], e.res[k]);
          cmp({"R4 R5 cout_chain", sz}, 16'(ac[k]), 16'(e.cc[k]));
          cmp({"R4 R5 cout_flag", sz}, 16'(af[k]), 16'(e.cf[k]));
          cmp({"R6 ovf", sz}, 16'(av[k]), 16'(e.ov[k]));
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [6];
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h7FFF; corners[4] = 16'h0001; corners[5] = 16'h8787;
    a = '0; b = '0; sub = 0; sel = 2'd3; chain = 0; data = 0; en = 2'b11;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give all-zero outputs (R8 combinational)
    #1;
    cmp("R8 idle result", r4, 16'h0);
    cmp("R8 idle carry", 16'({cc4, cf4, v4}), 16'h0);

    // corner sweep: R1 R2 R3 R4 R5 R6
    for (int s = 0; s < 2; s++)
      for (int cs = 0; cs < 4; cs++)
        for (int lv = 0; lv < 4; lv++)
          for (int ia = 0; ia < 6; ia++)
            for (int ib = 0; ib < 6; ib++)
              drive(corners[ia], corners[ib], bit'(s), 2'(cs), lv[0], lv[1],
                    2'((ia + ib + lv) % 4));

    // unselected-source check at the ports: R3
    for (int lv = 0; lv < 4; lv++) begin
      drive(16'hFFFF, 16'h0000, 1'b0, 2'd3, lv[0], lv[1], 2'b11); // R3 const 0: no carry
      drive(16'hFFFF, 16'h0000, 1'b0, 2'd2, lv[0], lv[1], 2'b11); // R3 const 1: carry out
    end

    // random operands: R7
    for (int i = 0; i < 600; i++)
      drive(16'($urandom), 16'($urandom), bit'($urandom_range(0, 1)),
            2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            2'($urandom_range(0, 3)));

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule